// File: doc/BRIEF.md
# Timer Time Base

A programmable time base built around three counters in series. A prescaler divides the block clock into counter ticks. A main counter steps once per tick and runs against a period limit. It can count up, count down, or bounce between zero and the limit in a symmetric (center-aligned) pattern. A repetition counter then lets a chosen number of counter wraps go by before it raises an update event.

Software reaches the block through a single-cycle write port. Divider, period and repetition values land in buffer registers. The working copies take them only at an update event, and software can raise one at any moment with a command write. An update event pulses an output for one cycle and sets a sticky flag, which software clears by writing a one. The period limit can bypass its buffer, so that a write reaches the counter at once.

Top module: `tbu_timebase`

Register addresses: 0 control, 1 divider, 2 period limit, 3 repetition, 4 command, 5 status. The control word holds these fields:
- bit 0: run.
- bit 1: count down in edge mode.
- bits 3:2: symmetric mode. 00 is edge counting, 01 updates at the bottom only, 10 at the top only, 11 at both ends.
- bit 4: buffer the period limit.
- bits 6:5: clock-division select.

## Requirements
- R1: With divider value P the counter advances once every P+1 clock cycles, so in up or down mode with limit A and repetition 0 an update occurs every (P+1)(A+1) cycles.
- R2: In up mode (control bits 1 and 3:2 all zero) the counter wraps from the limit to 0, and count reads 0 in the cycle update_pulse is high.
- R3: In down mode (control bit 1 set, bits 3:2 zero) the counter wraps from 0 to the limit, and count reads the limit in the cycle update_pulse is high.
- R4: In symmetric mode the counter reverses at both ends. At the top it moves on to A-1 with count_down high, and at the bottom to 1 with count_down low. Field 01 updates only at the bottom and field 10 only at the top, giving 2·A·(P+1) cycles per update. Field 11 updates at both ends, giving A·(P+1).
- R5: With repetition value N an update event occurs once every N+1 qualifying counter wraps.
- R6: Writes to the divider (address 1) and repetition (address 3) registers do not alter the running period until the next update event, after which the new values apply.
- R7: With control bit 4 set, a period-limit write waits for the next update event. With it clear, the write applies to the running count from the next cycle.
- R8: Writing 1 to bit 0 of address 4 forces an update event. It loads the buffered values and restarts the divider. The count restarts at 0, or at the new limit in down mode. update_pulse and update_flag are high in the following cycle.
- R9: update_flag is set by every update event and stays set. Writing 1 to bit 0 of address 5 clears it, writing 0 leaves it, and a simultaneous update wins.
- R10: While control bit 0 is clear the count does not change, except through a forced update.
- R11: clk_div_sel presents control bits 6:5.
- R12: After reset count is 0, count_down, update_pulse and update_flag are 0, and all buffered values are 0 except the limit, which is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | DATA_W (16) | Register write data |
| count | output | CNT_W (16) | Current counter value |
| count_down | output | 1 | Counter is currently counting down |
| update_pulse | output | 1 | One-cycle pulse after each update event |
| update_flag | output | 1 | Sticky update flag |
| clk_div_sel | output | 2 | Clock-division select from control |

## Verification
The hardest situation to reach is a buffered value arriving in the middle of a running period. To check that the current period still uses the old divider, repetition or limit and the next one uses the new value, the write must land between two updates. The bench therefore waits for an update pulse, writes at once while the count is still near its start, and measures two consecutive update intervals against computed lengths. Random divider, limit, repetition and mode settings from a fixed seed cover the period formulas in every counting mode.

// File: rtl/tbu_pkg.sv
`timescale 1ns/1ps
package tbu_pkg;
   // register map of the write port
   typedef enum logic [2:0] {
      A_CTRL  = 3'd0,
      A_PSC   = 3'd1,
      A_ARR   = 3'd2,
      A_REP   = 3'd3,
      A_EVGEN = 3'd4,
      A_STAT  = 3'd5
   } tbu_addr_e;

   // control word, LSB first: run, down, cms[1:0], arr_buf, div[1:0]
   typedef struct packed {
      logic [1:0] div;
      logic       arr_buf;
      logic [1:0] cms;
      logic       down;
      logic       run;
   } tbu_ctrl_t;

   localparam int CTRL_W = $bits(tbu_ctrl_t);
endpackage

// File: rtl/tbu_regs.sv
`timescale 1ns/1ps
module tbu_regs
   import tbu_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16,
   parameter int REP_W  = 8,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output tbu_ctrl_t         ctrl,
   output logic [PSC_W-1:0]  psc_pre,
   output logic [CNT_W-1:0]  arr_pre,
   output logic [CNT_W-1:0]  arr_nxt,
   output logic [REP_W-1:0]  rep_pre,
   output logic              force_upd,
   output logic              flag_clr
);
   logic hit_ctrl, hit_psc, hit_arr, hit_rep;

   assign hit_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign hit_psc   = wr_en && (wr_addr == ADDR_W'(A_PSC));
   assign hit_arr   = wr_en && (wr_addr == ADDR_W'(A_ARR));
   assign hit_rep   = wr_en && (wr_addr == ADDR_W'(A_REP));
   assign force_upd = wr_en && (wr_addr == ADDR_W'(A_EVGEN)) && wr_data[0];
   assign flag_clr  = wr_en && (wr_addr == ADDR_W'(A_STAT)) && wr_data[0];

   // value the limit buffer holds after this cycle
   assign arr_nxt = hit_arr ? wr_data[CNT_W-1:0] : arr_pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         psc_pre <= '0;
         arr_pre <= '1;
         rep_pre <= '0;
      end else begin
         if (hit_ctrl) ctrl    <= tbu_ctrl_t'(wr_data[CTRL_W-1:0]);
         if (hit_psc)  psc_pre <= wr_data[PSC_W-1:0];
         arr_pre <= arr_nxt;
         if (hit_rep)  rep_pre <= wr_data[REP_W-1:0];
      end
   end
endmodule

// File: rtl/tbu_prescaler.sv
`timescale 1ns/1ps
module tbu_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] pcnt;
   logic             at_end;

   assign at_end = (pcnt >= div);
   assign tick   = run && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pcnt <= '0;
      else if (restart)    pcnt <= '0;
      else if (run) begin
         if (at_end)       pcnt <= '0;
         else              pcnt <= pcnt + PSC_W'(1);
      end
   end
endmodule

// File: rtl/tbu_counter.sv
`timescale 1ns/1ps
module tbu_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] restart_val,
   input  logic             center,
   input  logic             edge_down,
   input  logic [CNT_W-1:0] arr,
   output logic [CNT_W-1:0] count,
   output logic             dir_down,
   output logic             top_evt,
   output logic             bot_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             dn_q, nxt_dn, at_top, at_bot;
   logic [CNT_W-1:0] nxt;

   assign dir_down = center ? dn_q : edge_down;

   always_comb begin
      nxt    = count;
      nxt_dn = dn_q;
      at_top = 1'b0;
      at_bot = 1'b0;
      if (!center) begin
         if (edge_down) begin
            if (count == '0) begin nxt = arr; at_bot = 1'b1; end
            else              nxt = count - ONE;
         end else begin
            if (count >= arr) begin nxt = '0; at_top = 1'b1; end
            else               nxt = count + ONE;
         end
      end else if (dn_q) begin
         if (count == '0) begin
            nxt    = (arr == '0) ? '0 : ONE;
            nxt_dn = 1'b0;
            at_bot = 1'b1;
         end else begin
            nxt = count - ONE;
         end
      end else begin
         if (count >= arr) begin
            nxt    = (arr == '0) ? '0 : arr - ONE;
            nxt_dn = 1'b1;
            at_top = 1'b1;
         end else begin
            nxt = count + ONE;
         end
      end
   end

   assign top_evt = tick && at_top;
   assign bot_evt = tick && at_bot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         dn_q  <= 1'b0;
      end else if (restart) begin
         count <= restart_val;
         dn_q  <= 1'b0;
      end else if (tick) begin
         count <= nxt;
         dn_q  <= nxt_dn;
      end
   end
endmodule

// File: rtl/tbu_repeat.sv
`timescale 1ns/1ps
module tbu_repeat #(
   parameter int REP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap,
   input  logic             reload,
   input  logic [REP_W-1:0] reload_val,
   output logic             hw_upd
);
   logic [REP_W-1:0] rcnt;

   assign hw_upd = wrap && (rcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rcnt <= '0;
      else if (reload)  rcnt <= reload_val;
      else if (wrap)    rcnt <= rcnt - REP_W'(1);
   end
endmodule

// File: rtl/tbu_timebase.sv
`timescale 1ns/1ps
module tbu_timebase
   import tbu_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16,
   parameter int REP_W  = 8,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count,
   output logic              count_down,
   output logic              update_pulse,
   output logic              update_flag,
   output logic [1:0]        clk_div_sel
);
   // elaboration-time parameter checks
   if (ADDR_W < 3)       begin : g_bad_addr $error("ADDR_W must be at least 3"); end
   if (DATA_W < CNT_W)   begin : g_bad_cnt  $error("DATA_W narrower than CNT_W"); end
   if (DATA_W < PSC_W)   begin : g_bad_psc  $error("DATA_W narrower than PSC_W"); end
   if (DATA_W < REP_W)   begin : g_bad_rep  $error("DATA_W narrower than REP_W"); end
   if (DATA_W < CTRL_W)  begin : g_bad_ctl  $error("DATA_W narrower than control word"); end
   if (CNT_W < 2)        begin : g_bad_w    $error("CNT_W must be at least 2"); end

   tbu_ctrl_t        ctrl;
   logic [PSC_W-1:0] psc_pre, psc_act;
   logic [CNT_W-1:0] arr_pre, arr_nxt, arr_act, restart_val;
   logic [REP_W-1:0] rep_pre;
   logic             force_upd, flag_clr, tick, center;
   logic             top_evt, bot_evt, wrap, hw_upd, uev;

   tbu_regs #(
      .CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctrl(ctrl), .psc_pre(psc_pre), .arr_pre(arr_pre),
      .arr_nxt(arr_nxt), .rep_pre(rep_pre), .force_upd(force_upd),
      .flag_clr(flag_clr)
   );

   tbu_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(force_upd),
      .div(psc_act), .tick(tick)
   );

   assign center      = (ctrl.cms != 2'b00);
   assign restart_val = (!center && ctrl.down) ? arr_nxt : '0;

   tbu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(force_upd),
      .restart_val(restart_val), .center(center), .edge_down(ctrl.down),
      .arr(arr_act), .count(count), .dir_down(count_down),
      .top_evt(top_evt), .bot_evt(bot_evt)
   );

   // which counter ends qualify as a wrap for the repetition stage
   assign wrap = center ? ((top_evt && ctrl.cms[1]) || (bot_evt && ctrl.cms[0]))
                        : (top_evt || bot_evt);

   tbu_repeat #(.REP_W(REP_W)) u_rep (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .reload(uev),
      .reload_val(rep_pre), .hw_upd(hw_upd)
   );

   assign uev = hw_upd || force_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_act      <= '0;
         arr_act      <= '1;
         update_pulse <= 1'b0;
         update_flag  <= 1'b0;
      end else begin
         update_pulse <= uev;
         if (uev)             psc_act <= psc_pre;
         if (!ctrl.arr_buf)   arr_act <= arr_nxt;
         else if (uev)        arr_act <= arr_pre;
         if (uev)             update_flag <= 1'b1;
         else if (flag_clr)   update_flag <= 1'b0;
      end
   end

   assign clk_div_sel = ctrl.div;
endmodule

// File: rtl/tbu_timebase_chk.sv
`timescale 1ns/1ps
module tbu_timebase_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             force_upd,
   input logic             uev,
   input logic             flag_clr,
   input logic             run,
   input logic             edge_up,
   input logic [CNT_W-1:0] count,
   input logic             update_pulse,
   input logic             update_flag
);
   // R9
   flag_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_pulse |-> update_flag);

   // R8
   force_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_upd |=> update_pulse);

   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !uev) |=> !update_flag);

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !force_upd) |=> $stable(count));

   // R2
   up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (update_pulse && edge_up && !$past(force_upd)) |-> (count == '0));
endmodule

bind tbu_timebase tbu_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .force_upd(force_upd), .uev(uev),
   .flag_clr(flag_clr), .run(ctrl.run),
   .edge_up((ctrl.cms == 2'b00) && !ctrl.down),
   .count(count), .update_pulse(update_pulse), .update_flag(update_flag)
);

// File: tb/tbu_timebase_test.sv
`timescale 1ns/1ps
module tbu_timebase_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] count;
   logic        count_down, update_pulse, update_flag;
   logic [1:0]  clk_div_sel;

   int     checks = 0;
   int     fails = 0;
   longint cyc = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tbu_timebase uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count(count), .count_down(count_down),
      .update_pulse(update_pulse), .update_flag(update_flag),
      .clk_div_sel(clk_div_sel)
   );

   // modes: 0 up, 1 down, 2 sym bottom, 3 sym top, 4 sym both
   function automatic logic [15:0] mkctrl(input bit run, input int mode,
                                          input bit abuf, input int div);
      logic       dn;
      logic [1:0] cms;
      dn  = (mode == 1);
      cms = (mode == 2) ? 2'b01 : (mode == 3) ? 2'b10 : (mode == 4) ? 2'b11 : 2'b00;
      return 16'({2'(div), abuf, cms, dn, run});
   endfunction

   function automatic int exp_period(input int mode, input int p, input int a, input int r);
      if (mode <= 1)      return (p + 1) * (a + 1) * (r + 1);
      else if (mode == 4) return a * (p + 1) * (r + 1);
      else                return 2 * a * (p + 1) * (r + 1);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_upd(output longint t);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!update_pulse && n < 20000);
      if (n >= 20000) chk(1'b0, "watchdog-update", n, 0);
      t = cyc;
   endtask

   task automatic setup(input int mode, input int p, input int a, input int r, input bit abuf);
      wr(3'd0, mkctrl(1'b0, mode, abuf, 0));
      wr(3'd1, 16'(p));
      wr(3'd2, 16'(a));
      wr(3'd3, 16'(r));
      wr(3'd4, 16'd1);
      wr(3'd0, mkctrl(1'b1, mode, abuf, 0));
   endtask

   task automatic measure(input int mode, input int p, input int a, input int r, input string req);
      longint t0, t1, t2;
      int e;
      setup(mode, p, a, r, 1'b1);
      e = exp_period(mode, p, a, r);
      wait_upd(t0);
      wait_upd(t1);
      chk((t1 - t0) == e, req, t1 - t0, e);
      // boundary value at the update
      case (mode)
         0: chk(count == 0, "R2 count at update", count, 0);
         1: chk(count == 16'(a), "R3 count at update", count, a);
         2: chk(count == 1 && !count_down, "R4 bottom reversal", count, 1);
         3: chk(count == 16'(a - 1) && count_down, "R4 top reversal", count, a - 1);
         default: chk(count == 1 || count == 16'(a - 1), "R4 either end", count, a - 1);
      endcase
      wait_upd(t2);
      chk((t2 - t1) == e, req, t2 - t1, e);
   endtask

   initial begin
      #4000000;
      chk(1'b0, "watchdog-global", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      longint t0, t1, t2;
      void'($urandom(32'h00c0ffee));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(count == 0, "R12 count", count, 0);
      chk(!update_flag && !update_pulse && !count_down, "R12 flags", update_flag, 0);

      // R8 forced update in down mode, counter stopped
      wr(3'd0, mkctrl(1'b0, 1, 1'b1, 0));
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd9);
      wr(3'd3, 16'd0);
      chk(count == 0, "R6 no load before update", count, 0);
      wr(3'd4, 16'd1);
      chk(count == 9, "R8 restart at limit", count, 9);
      chk(update_pulse && update_flag, "R8 pulse and flag", update_pulse, 1);
      repeat (5) @(negedge clk);
      chk(count == 9, "R10 halted count", count, 9);
      chk(!update_pulse && update_flag, "R9 flag sticky", update_flag, 1);

      // R9 clear behaviour
      wr(3'd5, 16'd0);
      chk(update_flag, "R9 write zero keeps flag", update_flag, 1);
      wr(3'd5, 16'd1);
      chk(!update_flag, "R9 write one clears", update_flag, 0);

      // R11 clock division field
      wr(3'd0, mkctrl(1'b0, 0, 1'b1, 2));
      chk(clk_div_sel == 2, "R11 div select", clk_div_sel, 2);

      // period shapes
      measure(0, 1, 4, 0, "R1 up period");
      measure(0, 0, 3, 2, "R5 repetition period");
      measure(1, 1, 6, 1, "R3 down period");
      measure(4, 1, 5, 0, "R4 both ends period");
      measure(2, 1, 5, 0, "R4 bottom only period");
      measure(3, 1, 5, 0, "R4 top only period");

      // R6 buffered divider and repetition
      setup(0, 0, 9, 0, 1'b1);
      wait_upd(t0);
      wr(3'd1, 16'd3);
      wr(3'd3, 16'd1);
      wait_upd(t1);
      wait_upd(t2);
      chk((t1 - t0) == 10, "R6 old values hold", t1 - t0, 10);
      chk((t2 - t1) == 80, "R6 new values after update", t2 - t1, 80);

      // R7 buffered limit
      setup(0, 0, 40, 0, 1'b1);
      wait_upd(t0);
      wr(3'd2, 16'd20);
      wait_upd(t1);
      wait_upd(t2);
      chk((t1 - t0) == 41, "R7 buffered limit waits", t1 - t0, 41);
      chk((t2 - t1) == 21, "R7 buffered limit applies", t2 - t1, 21);
      // R7 unbuffered limit
      setup(0, 0, 40, 0, 1'b0);
      wait_upd(t0);
      wr(3'd2, 16'd20);
      wait_upd(t1);
      chk((t1 - t0) == 21, "R7 unbuffered limit immediate", t1 - t0, 21);

      // R8 forced update restarts a running count
      setup(0, 0, 50, 0, 1'b1);
      repeat (17) @(negedge clk);
      wr(3'd4, 16'd1);
      t0 = cyc;
      chk(count == 0, "R8 restart at zero", count, 0);
      wait_upd(t1);
      chk((t1 - t0) == 51, "R8 period from forced update", t1 - t0, 51);

      // random settings, R1 and R5
      for (int i = 0; i < 8; i++) begin
         int m, p, a, r;
         m = int'($urandom % 5);
         p = int'($urandom % 3);
         a = 1 + int'($urandom % 10);
         r = int'($urandom % 3);
         measure(m, p, a, r, "R1 R5 random period");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule